// File: doc/BRIEF.md
# Pipeline Trap and Interrupt Annulment Controller

This block is the control side of trap handling for a five-stage in-order pipeline with fetch, register-read, ALU, memory and write-back stages. Three kinds of synchronous event are raised inside the pipeline. An undefined opcode is decoded in the register-read stage. An arithmetic fault is raised in the ALU stage. An access fault is raised in the memory stage. An external interrupt request arrives asynchronously. For each cycle the block chooses at most one event to take. It then redirects the next fetch address to a handler vector, annuls every instruction younger than the chosen one, and tells the datapath to overwrite the chosen stage's instruction with a synthetic never-taken branch. That branch deposits its own PC+4 in the exception-link register when it retires.

An interrupt does not annul anything. Instead, the instruction just fetched is overwritten by the synthetic branch. Because that instruction never executes, handler software resumes at the link value minus 4. The block also passes on a front-end stall request from the load interlock. It keeps a small shadow record of which in-flight slots were annulled or are stall bubbles, so that such a slot can never raise a trap later.

Top module: `exc_annul_ctl`

## Requirements
- R1: After reset, with no event inputs raised, `annul`, `force_bne`, `redirect`, `vec_addr` and `front_hold` are all zero.
- R2: An interrupt request taken alone sets `force_bne` to 4'b0001 (bit 0 = fetch stage), leaves `annul` at zero, raises `redirect` and drives `vec_addr` = VEC_IRQ in the same cycle.
- R3: An undefined opcode taken alone sets `force_bne` to 4'b0010 (bit 1 = register-read stage), sets `annul` to 4'b0001, raises `redirect` and drives `vec_addr` = VEC_BADOP in the same cycle.
- R4: An arithmetic fault taken alone sets `force_bne` to 4'b0100 (bit 2 = ALU stage), sets `annul` to 4'b0011, raises `redirect` and drives `vec_addr` = VEC_FAULT in the same cycle.
- R5: A memory fault taken alone sets `force_bne` to 4'b1000 (bit 3 = memory stage), sets `annul` to 4'b0111, raises `redirect` and drives `vec_addr` = VEC_FAULT in the same cycle.
- R6: When several events arrive in one cycle, only the oldest is taken, in the order memory fault, then arithmetic fault, then undefined opcode, then interrupt. The outputs equal those for the winner alone.
- R7: `front_hold` follows `front_stall` in cycles that take no event. An interrupt request is ignored while `front_stall` is high. A live fault or undefined opcode is taken during a stall, and `front_hold` then drops to 0.
- R8: An instruction annulled in an earlier cycle, or a bubble that a stall pushed into the ALU stage, raises no trap as it moves down the pipeline. Its event input is ignored and all outputs stay zero. An annulled register-read instruction held by a stall stays annulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Asynchronous interrupt request, already synchronised |
| rf_bad_op | input | 1 | Undefined opcode decoded in the register-read stage |
| alu_fault | input | 1 | Arithmetic fault raised in the ALU stage |
| mem_fault | input | 1 | Access fault raised in the memory stage |
| front_stall | input | 1 | Load interlock request to freeze fetch and register-read |
| annul | output | 4 | Per-stage annul, bit 0 fetch to bit 3 memory |
| force_bne | output | 4 | Per-stage overwrite with the never-taken link branch |
| redirect | output | 1 | Select handler vector as next PC |
| vec_addr | output | AW | Handler vector, zero when no event is taken |
| front_hold | output | 1 | Freeze fetch and register-read this cycle |

## Verification
Every output is combinational from the event inputs and the shadow record. An event's result therefore appears in the same cycle the event is presented. The bench drives each cycle's inputs on the falling edge and samples two nanoseconds later, before the next rising edge. Annulment and stall bubbles change the shadow record at the rising edge, so they affect only the following cycles. The bench steps through those cycles one at a time: it checks that a dead slot stays silent one cycle later in the register-read stage, two cycles later in the ALU stage and three cycles later in the memory stage, and that the same stage takes a live event again in the cycle after that.

// File: rtl/exc_ctl_pkg.sv
package exc_ctl_pkg;

    localparam int NSTG  = 4;
    localparam int S_IF  = 0;
    localparam int S_RF  = 1;
    localparam int S_ALU = 2;
    localparam int S_MEM = 3;

    typedef logic [NSTG-1:0] stgvec_t;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_IRQ   = 2'd1,
        CAUSE_BADOP = 2'd2,
        CAUSE_FAULT = 2'd3
    } cause_e;

    function automatic cause_e cause_of(input stgvec_t win);
        if (win[S_MEM] || win[S_ALU]) return CAUSE_FAULT;
        if (win[S_RF])                return CAUSE_BADOP;
        if (win[S_IF])                return CAUSE_IRQ;
        return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/exc_prio.sv
module exc_prio
    import exc_ctl_pkg::*;
(
    input  stgvec_t req,
    output stgvec_t win,
    output stgvec_t kill
);
    generate
        for (genvar s = 0; s < NSTG; s++) begin : g_stage
            if (s == NSTG - 1) begin : g_oldest
                assign win[s]  = req[s];
                assign kill[s] = 1'b0;
            end else begin : g_younger
                assign win[s]  = req[s] & ~(|req[NSTG-1:s+1]);
                assign kill[s] = |win[NSTG-1:s+1];
            end
        end
    endgenerate

    always_comb begin
        if (!$isunknown(req)) begin
            p_single_winner_r6: assert ($onehot0(win));
        end
    end

endmodule

// File: rtl/exc_shadow.sv
module exc_shadow
    import exc_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  stgvec_t           kill,
    output logic [NSTG-1:1]   dead
);
    logic [NSTG-1:1] dead_d;

    assign dead_d[S_RF] = hold ? dead[S_RF] : kill[S_IF];

    generate
        for (genvar s = S_ALU; s < NSTG; s++) begin : g_adv
            if (s == S_ALU) begin : g_bubble
                assign dead_d[s] = hold | dead[s-1] | kill[s-1];
            end else begin : g_pass
                assign dead_d[s] = dead[s-1] | kill[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) dead <= '0;
        else     dead <= dead_d;
    end

endmodule

// File: rtl/exc_annul_ctl.sv
module exc_annul_ctl
    import exc_ctl_pkg::*;
#(
    parameter int          AW        = 32,
    parameter logic [31:0] VEC_BADOP = 32'h0000_0080,
    parameter logic [31:0] VEC_FAULT = 32'h0000_0100,
    parameter logic [31:0] VEC_IRQ   = 32'h0000_0180
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          irq_req,
    input  logic          rf_bad_op,
    input  logic          alu_fault,
    input  logic          mem_fault,
    input  logic          front_stall,
    output logic [3:0]    annul,
    output logic [3:0]    force_bne,
    output logic          redirect,
    output logic [AW-1:0] vec_addr,
    output logic          front_hold
);
    stgvec_t         req;
    stgvec_t         win;
    stgvec_t         kill;
    logic [NSTG-1:1] dead;
    cause_e          cause;

    always_comb begin
        req        = '0;
        req[S_IF]  = irq_req   & ~front_stall;
        req[S_RF]  = rf_bad_op & ~dead[S_RF];
        req[S_ALU] = alu_fault & ~dead[S_ALU];
        req[S_MEM] = mem_fault & ~dead[S_MEM];
    end

    exc_prio u_prio (
        .req  (req),
        .win  (win),
        .kill (kill)
    );

    assign redirect   = |win;
    assign front_hold = front_stall & ~redirect;
    assign annul      = kill;
    assign force_bne  = win;
    assign cause      = cause_of(win);

    always_comb begin
        unique case (cause)
            CAUSE_FAULT: vec_addr = AW'(VEC_FAULT);
            CAUSE_BADOP: vec_addr = AW'(VEC_BADOP);
            CAUSE_IRQ:   vec_addr = AW'(VEC_IRQ);
            default:     vec_addr = '0;
        endcase
    end

    exc_shadow u_shadow (
        .clk  (clk),
        .rst  (rst),
        .hold (front_hold),
        .kill (kill),
        .dead (dead)
    );

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (rst)
        front_stall |-> !force_bne[S_IF]);

    p_hold_no_redirect_r7: assert property (@(posedge clk) disable iff (rst)
        front_hold |-> !redirect);

    p_alu_shadow_r8: assert property (@(posedge clk) disable iff (rst)
        force_bne[S_ALU] |=> !force_bne[S_ALU]);

    p_mem_shadow_r8: assert property (@(posedge clk) disable iff (rst)
        force_bne[S_MEM] |=> !force_bne[S_MEM]);

    p_dead_alu_silent_r8: assert property (@(posedge clk) disable iff (rst)
        dead[S_ALU] |-> !force_bne[S_ALU]);

    p_vec_on_redirect_r2: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (vec_addr != '0));

endmodule

// File: tb/tb_exc_annul_ctl.sv
`timescale 1ns/1ps
module tb_exc_annul_ctl;

    localparam logic [31:0] VB = 32'h0000_0080;
    localparam logic [31:0] VF = 32'h0000_0100;
    localparam logic [31:0] VQ = 32'h0000_0180;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_req = 1'b0, rf_bad_op = 1'b0, alu_fault = 1'b0;
    logic        mem_fault = 1'b0, front_stall = 1'b0;
    logic [3:0]  annul, force_bne;
    logic        redirect, front_hold;
    logic [31:0] vec_addr;

    typedef struct {
        logic [3:0]  an;
        logic [3:0]  fb;
        logic        rd;
        logic [31:0] va;
        logic        hd;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    always #2.5 clk = ~clk;

    exc_annul_ctl #(.AW(32), .VEC_BADOP(VB), .VEC_FAULT(VF), .VEC_IRQ(VQ)) dut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .rf_bad_op(rf_bad_op),
        .alu_fault(alu_fault), .mem_fault(mem_fault), .front_stall(front_stall),
        .annul(annul), .force_bne(force_bne), .redirect(redirect),
        .vec_addr(vec_addr), .front_hold(front_hold)
    );

    task automatic step(input logic q, input logic b, input logic a, input logic m,
                        input logic st, input logic [3:0] ea, input logic [3:0] ef,
                        input logic er, input logic [31:0] ev, input logic eh,
                        input string tag);
        exp_t e;
        @(negedge clk);
        irq_req = q; rf_bad_op = b; alu_fault = a; mem_fault = m; front_stall = st;
        e.an = ea; e.fb = ef; e.rd = er; e.va = ev; e.hd = eh; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0,0,0,0,0, 4'b0,4'b0,0,32'h0,0, tag);
    endtask

    // monitor: pops one expected item per cycle, 2 ns after the drive
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                total++;
                if (annul !== e.an || force_bne !== e.fb || redirect !== e.rd ||
                    vec_addr !== e.va || front_hold !== e.hd) begin
                    bad++;
                    $display("FAIL %s: got annul=%b force=%b redir=%b vec=%h hold=%b exp annul=%b force=%b redir=%b vec=%h hold=%b",
                             e.tag, annul, force_bne, redirect, vec_addr, front_hold,
                             e.an, e.fb, e.rd, e.va, e.hd);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step(0,0,0,0,0, 4'b0000,4'b0000,0,32'h0,0, "R1 idle after reset");
        step(1,0,0,0,0, 4'b0000,4'b0001,1,VQ,0, "R2 interrupt alone");
        step(0,0,0,0,0, 4'b0000,4'b0000,0,32'h0,0, "R2 quiet after interrupt");
        step(0,1,0,0,0, 4'b0001,4'b0010,1,VB,0, "R3 bad opcode alone");
        idle(4, "R3 drain");
        step(0,0,1,0,0, 4'b0011,4'b0100,1,VF,0, "R4 alu fault alone");
        step(0,1,1,0,0, 4'b0000,4'b0000,0,32'h0,0, "R8 annulled rf and alu silent");
        step(0,0,1,1,0, 4'b0000,4'b0000,0,32'h0,0, "R8 annulled alu and mem silent");
        step(0,0,0,1,0, 4'b0000,4'b0000,0,32'h0,0, "R8 annulled mem silent");
        step(0,0,0,1,0, 4'b0111,4'b1000,1,VF,0, "R5 mem fault alone");
        idle(4, "R5 drain");
        step(1,1,1,1,0, 4'b0111,4'b1000,1,VF,0, "R6 mem wins over all");
        idle(4, "R6 drain a");
        step(1,1,1,0,0, 4'b0011,4'b0100,1,VF,0, "R6 alu wins over rf and irq");
        idle(4, "R6 drain b");
        step(1,1,0,0,0, 4'b0001,4'b0010,1,VB,0, "R6 bad opcode wins over irq");
        idle(4, "R6 drain c");
        step(0,0,0,0,1, 4'b0000,4'b0000,0,32'h0,1, "R7 stall passes to hold");
        step(1,0,0,0,1, 4'b0000,4'b0000,0,32'h0,1, "R7 interrupt ignored under stall");
        step(0,0,1,0,0, 4'b0000,4'b0000,0,32'h0,0, "R8 bubble in alu silent");
        step(0,0,0,1,0, 4'b0000,4'b0000,0,32'h0,0, "R8 bubble in mem silent");
        step(0,0,0,1,0, 4'b0111,4'b1000,1,VF,0, "R5 mem live after bubble");
        idle(4, "R5 drain b");
        step(0,0,1,0,1, 4'b0011,4'b0100,1,VF,0, "R7 alu fault overrides stall");
        idle(4, "R7 drain a");
        step(0,1,0,0,1, 4'b0001,4'b0010,1,VB,0, "R7 bad opcode overrides stall");
        idle(4, "R7 drain b");
        step(0,0,1,0,0, 4'b0011,4'b0100,1,VF,0, "R4 alu fault before held rf");
        step(0,0,0,0,1, 4'b0000,4'b0000,0,32'h0,1, "R7 hold with dead rf");
        step(0,1,0,0,0, 4'b0000,4'b0000,0,32'h0,0, "R8 held annulled rf silent");
        step(0,1,0,0,0, 4'b0001,4'b0010,1,VB,0, "R3 rf live again");
        idle(2, "end");
        wait (exp_q.size() == 0);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule